// File: doc/BRIEF.md
# Secure Real-Time Clock Register Block

This block is a memory-mapped real-time clock. It keeps a time value made of a 32-bit seconds word and a sub-second fraction word. The fraction advances on each tick while counting is enabled and carries into the seconds word when it wraps. A compare value of the same shape can raise a sticky alarm flag. A 32-bit register port provides word-addressed reads and writes.

Writes to every register except status are deferred. An accepted write occupies a single-slot pipeline for a fixed number of ticks. It is then committed and reported through done or error flags in the status word. Status is write-one-to-clear and takes effect at once. The block comes out of reset in a non-valid state, and until software leaves that state every deferred write fails. The counter stays frozen until its seconds word has been written at least once and the run bit is set. One interrupt line gathers the enabled status flags.

Top module: `srtc_regs`

## Requirements
- R1: After reset, seconds, fraction, alarm low, control and interrupt enable read 0. Alarm high reads 0xFFFFFFFF. Status reads 0x00000202: non-valid (bit 1) and ready (bit 9) are set. irq_o is 0.
- R2: Register word indices are 0 seconds, 1 fraction (zero-extended), 2 alarm high, 3 alarm low, 4 control, 5 status, 6 interrupt enable. Control keeps only bit 3 (run). Interrupt enable keeps only bits 9, 8, 7 and 4. All other bits read 0.
- R3: A write to any index other than 5, accepted while idle, sets busy (status bit 10) and clears ready (bit 9). It is committed on the WR_DELAY-th (default 4) following cycle with tick_i high, and cycles with tick_i low do not advance it. On a successful commit the register updates, busy clears and done (bit 8) sets.
- R4: A non-status write that arrives while busy is dropped and sets error (bit 7). The pending write still commits unchanged.
- R5: While non-valid is set, a deferred write commits with error set, done left clear and the register unchanged. Non-valid clears only on a status write with bits 1 and 0 both 1.
- R6: Status writes act in the cycle they are issued, also while busy, and never count as dropped. A 1 in bit 8, 7 or 4 clears that flag.
- R7: Time holds still unless the run bit is 1 and a successful seconds write has occurred since reset. A failed seconds write does not count.
- R8: When running, each tick_i adds 1 to the fraction, and a wrap of the FRAC_W-bit fraction adds 1 to seconds.
- R9: The alarm flag (status bit 4) sets on the clock edge at which the time equals {alarm high, alarm low}, and it holds until cleared. An alarm high of 0xFFFFFFFF disables the compare.
- R10: irq_o is the OR of status bits 9, 8, 7 and 4, each gated by the enable bit at the same position.
- R11: Reads have no side effects on any register or flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Time and write-pipeline advance enable |
| we_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register word index |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i (combinational) |
| irq_o | output | 1 | Interrupt request |

## Verification
The counter is driven with a run of single ticks from a seed chosen so that the fraction wraps twice. Each step is compared with the arithmetic sum, which separates carry errors from missed increments. Deferred writes are applied in four situations: while non-valid, with tick gaps inserted, overlapped by a second write, and overlapped by a status clear. These separate the timing, the drop, the failure and the immediate-clear paths. The alarm is swept one tick at a time across its target, and the no-alarm setting is tried with the time placed exactly on the compare value. Each interrupt source is enabled by itself and raised and cleared in turn.

// File: rtl/srtc_pkg.sv
package srtc_pkg;
  typedef enum logic [2:0] {
    REG_SEC    = 3'd0,
    REG_FRAC   = 3'd1,
    REG_ALM_HI = 3'd2,
    REG_ALM_LO = 3'd3,
    REG_CTRL   = 3'd4,
    REG_STAT   = 3'd5,
    REG_IEN    = 3'd6
  } reg_sel_e;

  localparam int unsigned CTRL_RUN = 3;
  localparam int unsigned ST_BUSY  = 10;
  localparam int unsigned ST_READY = 9;
  localparam int unsigned ST_DONE  = 8;
  localparam int unsigned ST_ERR   = 7;
  localparam int unsigned ST_ALM   = 4;
  localparam int unsigned ST_NV    = 1;
  localparam int unsigned ST_SV    = 0;

  localparam logic [31:0] IEN_MASK = 32'h0000_0390;
endpackage

// File: rtl/srtc_wr_pipe.sv
module srtc_wr_pipe #(
  parameter int unsigned DELAY = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        req_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] data_i,
  output logic        busy_o,
  output logic        drop_o,
  output logic        commit_o,
  output logic [2:0]  addr_o,
  output logic [31:0] data_o
);
  localparam int unsigned CW = (DELAY > 1) ? $clog2(DELAY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DELAY - 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  logic [2:0]    addr_q;
  logic [31:0]   data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      addr_q <= '0;
      data_q <= '0;
    end else if (busy_q) begin
      if (tick_i) begin
        if (cnt_q == LAST) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end else if (req_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
      addr_q <= addr_i;
      data_q <= data_i;
    end
  end

  assign busy_o   = busy_q;
  assign drop_o   = busy_q && req_i;
  assign commit_o = busy_q && tick_i && (cnt_q == LAST);
  assign addr_o   = addr_q;
  assign data_o   = data_q;
endmodule

// File: rtl/srtc_time_cnt.sv
module srtc_time_cnt #(
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              ld_sec_i,
  input  logic              ld_frac_i,
  input  logic [31:0]       ld_data_i,
  output logic [31:0]       sec_o,
  output logic [FRAC_W-1:0] frac_o,
  output logic              seeded_o
);
  logic [31:0]       sec_q;
  logic [FRAC_W-1:0] frac_q;
  logic              seeded_q;
  logic              step;

  assign step = run_i && seeded_q && tick_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sec_q    <= '0;
      frac_q   <= '0;
      seeded_q <= 1'b0;
    end else begin
      if (ld_sec_i) seeded_q <= 1'b1;
      if (ld_sec_i)                   sec_q <= ld_data_i;
      else if (step && (&frac_q))     sec_q <= sec_q + 32'd1;
      if (ld_frac_i)  frac_q <= ld_data_i[FRAC_W-1:0];
      else if (step)  frac_q <= frac_q + 1'b1;
    end
  end

  assign sec_o    = sec_q;
  assign frac_o   = frac_q;
  assign seeded_o = seeded_q;
endmodule

// File: rtl/srtc_alarm.sv
module srtc_alarm #(
  parameter int unsigned FRAC_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ld_hi_i,
  input  logic              ld_lo_i,
  input  logic [31:0]       ld_data_i,
  input  logic [31:0]       sec_i,
  input  logic [FRAC_W-1:0] frac_i,
  output logic [31:0]       hi_o,
  output logic [FRAC_W-1:0] lo_o,
  output logic              match_o
);
  logic [31:0]       hi_q;
  logic [FRAC_W-1:0] lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '1;
      lo_q <= '0;
    end else begin
      if (ld_hi_i) hi_q <= ld_data_i;
      if (ld_lo_i) lo_q <= ld_data_i[FRAC_W-1:0];
    end
  end

  // all-ones high word parks the compare
  assign match_o = (hi_q != '1) && (sec_i == hi_q) && (frac_i == lo_q);
  assign hi_o    = hi_q;
  assign lo_o    = lo_q;
endmodule

// File: rtl/srtc_regs.sv
module srtc_regs
  import srtc_pkg::*;
#(
  parameter int unsigned FRAC_W   = 32,
  parameter int unsigned WR_DELAY = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  logic              st_wr, pipe_req;
  logic              busy_w, drop_w, commit_w;
  logic [2:0]        c_addr;
  logic [31:0]       c_data;
  logic              commit_ok, commit_bad;
  logic              run_q, done_q, err_q, alm_q, nv_q;
  logic [31:0]       ien_q;
  logic [31:0]       sec_w, alm_hi_w;
  logic [FRAC_W-1:0] frac_w, alm_lo_w;
  logic              seeded_w, match_w;
  logic [31:0]       stat_w;

  assign st_wr    = we_i && (addr_i == REG_STAT);
  assign pipe_req = we_i && (addr_i != REG_STAT);

  srtc_wr_pipe #(.DELAY(WR_DELAY)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .req_i   (pipe_req),
    .addr_i  (addr_i),
    .data_i  (wdata_i),
    .busy_o  (busy_w),
    .drop_o  (drop_w),
    .commit_o(commit_w),
    .addr_o  (c_addr),
    .data_o  (c_data)
  );

  assign commit_ok  = commit_w && !nv_q;
  assign commit_bad = commit_w && nv_q;

  srtc_time_cnt #(.FRAC_W(FRAC_W)) u_time (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .run_i    (run_q),
    .ld_sec_i (commit_ok && (c_addr == REG_SEC)),
    .ld_frac_i(commit_ok && (c_addr == REG_FRAC)),
    .ld_data_i(c_data),
    .sec_o    (sec_w),
    .frac_o   (frac_w),
    .seeded_o (seeded_w)
  );

  srtc_alarm #(.FRAC_W(FRAC_W)) u_alarm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ld_hi_i  (commit_ok && (c_addr == REG_ALM_HI)),
    .ld_lo_i  (commit_ok && (c_addr == REG_ALM_LO)),
    .ld_data_i(c_data),
    .sec_i    (sec_w),
    .frac_i   (frac_w),
    .hi_o     (alm_hi_w),
    .lo_o     (alm_lo_w),
    .match_o  (match_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= 1'b0;
      ien_q <= '0;
    end else if (commit_ok) begin
      if (c_addr == REG_CTRL) run_q <= c_data[CTRL_RUN];
      if (c_addr == REG_IEN)  ien_q <= c_data & IEN_MASK;
    end
  end

  // sticky flags: set beats a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      alm_q  <= 1'b0;
      nv_q   <= 1'b1;
    end else begin
      if (commit_ok)                      done_q <= 1'b1;
      else if (st_wr && wdata_i[ST_DONE]) done_q <= 1'b0;
      if (commit_bad || drop_w)           err_q  <= 1'b1;
      else if (st_wr && wdata_i[ST_ERR])  err_q  <= 1'b0;
      if (match_w)                        alm_q  <= 1'b1;
      else if (st_wr && wdata_i[ST_ALM])  alm_q  <= 1'b0;
      if (st_wr && wdata_i[ST_NV] && wdata_i[ST_SV]) nv_q <= 1'b0;
    end
  end

  always_comb begin
    stat_w           = '0;
    stat_w[ST_BUSY]  = busy_w;
    stat_w[ST_READY] = !busy_w;
    stat_w[ST_DONE]  = done_q;
    stat_w[ST_ERR]   = err_q;
    stat_w[ST_ALM]   = alm_q;
    stat_w[ST_NV]    = nv_q;
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      REG_SEC:    rdata_o = sec_w;
      REG_FRAC:   rdata_o = 32'(frac_w);
      REG_ALM_HI: rdata_o = alm_hi_w;
      REG_ALM_LO: rdata_o = 32'(alm_lo_w);
      REG_CTRL:   rdata_o[CTRL_RUN] = run_q;
      REG_STAT:   rdata_o = stat_w;
      REG_IEN:    rdata_o = ien_q;
      default:    rdata_o = '0;
    endcase
  end

  assign irq_o = |(stat_w & ien_q);
endmodule

// File: rtl/srtc_regs_chk.sv
module srtc_regs_chk #(
  parameter int unsigned FRAC_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick_i,
  input logic              we_i,
  input logic [2:0]        addr_i,
  input logic [31:0]       wdata_i,
  input logic              irq_o,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic              nv,
  input logic              alm,
  input logic              run,
  input logic              seeded,
  input logic [31:0]       sec,
  input logic [FRAC_W-1:0] frac,
  input logic [31:0]       alm_hi,
  input logic [31:0]       ien
);
  localparam int unsigned TW = 32 + FRAC_W;

  a_r3_end_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy) |-> (done || err));

  a_r4_drop_err: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && we_i && addr_i != 3'd5) |=> err);

  a_r5_nv_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(nv) |-> $past(we_i && addr_i == 3'd5 && wdata_i[1:0] == 2'b11));

  a_r7_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!(run && seeded) && !busy) |=> ($stable(sec) && $stable(frac)));

  a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && seeded && tick_i && !busy) |=> ({sec, frac} == $past({sec, frac}) + TW'(1)));

  a_r9_parked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm) |-> ($past(alm_hi) != 32'hFFFF_FFFF));

  a_r10_ready_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy && ien[9]) |-> irq_o);
endmodule

bind srtc_regs srtc_regs_chk #(.FRAC_W(FRAC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .tick_i (tick_i),
  .we_i   (we_i),
  .addr_i (addr_i),
  .wdata_i(wdata_i),
  .irq_o  (irq_o),
  .busy   (busy_w),
  .done   (done_q),
  .err    (err_q),
  .nv     (nv_q),
  .alm    (alm_q),
  .run    (run_q),
  .seeded (seeded_w),
  .sec    (sec_w),
  .frac   (frac_w),
  .alm_hi (alm_hi_w),
  .ien    (ien_q)
);

// File: tb/srtc_regs_bench.sv
`timescale 1ns/1ps
module srtc_regs_bench;
  localparam int unsigned FW = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int          total = 0;
  int          bad = 0;

  always #2 clk = ~clk;

  srtc_regs #(.FRAC_W(FW), .WR_DELAY(4)) u_srtc_regs (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1; v = rdata;
  endtask

  task automatic rd_irq(output logic v);
    @(negedge clk); #1; v = irq;
  endtask

  task automatic wr_start(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = a; wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_start(a, d);
    ticks(4);
  endtask

  task automatic st_wr(input logic [31:0] d);
    wr_start(3'd5, d);
  endtask

  initial begin
    #400000;
    total++; bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2, v3;
    logic        q;
    int          t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(3'd0, v); chk("R1 sec", v, 0);
    rd(3'd1, v); chk("R1 frac", v, 0);
    rd(3'd2, v); chk("R1 alm_hi", v, 32'hFFFF_FFFF);
    rd(3'd3, v); chk("R1 alm_lo", v, 0);
    rd(3'd4, v); chk("R1 ctrl", v, 0);
    rd(3'd5, v); chk("R1 stat", v, 32'h202);
    rd(3'd6, v); chk("R1 ien", v, 0);
    rd_irq(q);   chk("R1 irq", 32'(q), 0);

    // R5 writes fail while non-valid
    wr(3'd0, 32'd5);
    rd(3'd5, v); chk("R5 fail stat", v, 32'h282);
    rd(3'd0, v); chk("R5 sec kept", v, 0);
    st_wr(32'h2);
    rd(3'd5, v); chk("R5 nv needs both bits", v, 32'h282);
    st_wr(32'h83);
    rd(3'd5, v); chk("R5 nv left, R6 err cleared", v, 32'h200);

    // R7 run without seeding: frozen
    wr(3'd4, 32'h8);
    ticks(10);
    rd(3'd0, v); chk("R7 unseeded sec", v, 0);
    rd(3'd1, v); chk("R7 unseeded frac", v, 0);
    wr(3'd4, 32'h0);
    st_wr(32'h100);
    rd(3'd5, v); chk("R6 done cleared", v, 32'h200);

    // R3 commit timing with tick gaps
    wr_start(3'd0, 32'd7);
    rd(3'd5, v); chk("R3 busy no tick", v, 32'h400);
    ticks(3);
    rd(3'd0, v); chk("R3 sec before last tick", v, 0);
    rd(3'd5, v); chk("R3 still busy", v, 32'h400);
    ticks(1);
    rd(3'd0, v); chk("R3 sec committed", v, 7);
    rd(3'd5, v); chk("R3 done", v, 32'h300);
    ticks(5);
    rd(3'd1, v); chk("R7 run off frac", v, 0);
    rd(3'd0, v); chk("R7 run off sec", v, 7);
    st_wr(32'h100);

    // R4 overlapped write dropped
    wr_start(3'd1, 32'd3);
    wr_start(3'd3, 32'd9);
    rd(3'd5, v); chk("R4 busy+err", v, 32'h480);
    ticks(4);
    rd(3'd1, v); chk("R4 first write kept", v, 3);
    rd(3'd3, v); chk("R4 dropped no effect", v, 0);
    rd(3'd5, v); chk("R4 stat", v, 32'h380);

    // R6 status write while busy
    wr_start(3'd3, 32'd2);
    st_wr(32'h80);
    rd(3'd5, v); chk("R6 clear while busy", v, 32'h500);
    ticks(4);
    rd(3'd3, v); chk("R6 pending write intact", v, 2);
    rd(3'd5, v); chk("R6 stat after", v, 32'h300);
    st_wr(32'h100);

    // R2 field masking
    wr(3'd4, 32'hFFFF_FFF7);
    rd(3'd4, v); chk("R2 ctrl masked", v, 0);
    st_wr(32'h100);

    // R8 counting sweep across two fraction wraps
    wr(3'd0, 32'h10);
    wr(3'd1, 32'h0);
    wr(3'd4, 32'h8);
    for (int i = 1; i <= 40; i++) begin
      ticks(1);
      t = 32'h10 * 16 + i;
      rd(3'd0, v); chk($sformatf("R8 sec step %0d", i), v, 32'(t / 16));
      rd(3'd1, v); chk($sformatf("R8 frac step %0d", i), v, 32'(t % 16));
    end

    // R9 alarm sweep; time is now 296
    wr(3'd3, 32'd5);
    wr(3'd2, 32'h13);
    rd(3'd5, v); chk("R9 no early alarm", (v >> 4) & 1, 0);
    for (int tt = 305; tt <= 312; tt++) begin
      ticks(1);
      rd(3'd5, v); chk($sformatf("R9 alarm at %0d", tt), (v >> 4) & 1, (tt >= 309) ? 1 : 0);
    end
    rd_irq(q); chk("R10 alarm masked", 32'(q), 0);
    wr(3'd4, 32'h0);

    // R10 interrupt sources
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); chk("R2 ien masked", v, 32'h390);
    wr(3'd6, 32'h10);
    rd_irq(q); chk("R10 alarm irq", 32'(q), 1);
    st_wr(32'h10);
    rd_irq(q); chk("R10 alarm irq cleared", 32'(q), 0);
    wr(3'd6, 32'h100);
    rd_irq(q); chk("R10 done irq", 32'(q), 1);
    st_wr(32'h100);
    rd_irq(q); chk("R10 done irq cleared", 32'(q), 0);
    wr(3'd6, 32'h80);
    wr_start(3'd3, 32'd0);
    wr_start(3'd3, 32'd1);
    rd_irq(q); chk("R10 err irq", 32'(q), 1);
    ticks(4);
    st_wr(32'h80);
    rd_irq(q); chk("R10 err irq cleared", 32'(q), 0);
    wr(3'd6, 32'h200);
    rd_irq(q); chk("R10 ready irq", 32'(q), 1);
    wr_start(3'd3, 32'd0);
    rd_irq(q); chk("R10 ready low while busy", 32'(q), 0);
    ticks(4);
    rd_irq(q); chk("R10 ready back", 32'(q), 1);

    // R9 parked compare with time sitting on the compare value
    wr(3'd6, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0);
    st_wr(32'h10);
    ticks(3);
    rd(3'd5, v); chk("R9 parked alarm", (v >> 4) & 1, 0);

    // R11 reads are side-effect free
    st_wr(32'h190);
    rd(3'd5, v); rd(3'd5, v2); rd(3'd5, v3);
    chk("R11 stat reread", v2, v);
    chk("R11 stat reread 2", v3, 32'h200);
    rd(3'd0, v); rd(3'd0, v2);
    chk("R11 sec reread", v2, 32'hFFFF_FFFF);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule